// File: doc/BRIEF.md
# DMA Request Activation Controller

This block converts an active-low external DMA request pin into single-cycle transfer request pulses for one DMA channel, and drives the channel's active-low transfer-end pin. The request pin first passes through a synchronizer. It can then be sensed in one of two ways. In edge mode, a three-state sequence (armed, waiting for the engine, re-arm on high) yields one request per low period. In level mode, a request is raised on every cycle in which the pin is low and the engine can accept a transfer.

Setting the channel enable arms the sequence, so the first activation needs only a low level. A request that was already pending before the enable is therefore taken. Clearing the enable returns the block to idle at once.

The transfer-end strobe is driven low for the cycle in which the final transfer completes. It is withheld when both transfer addresses are on-chip and an external write cycle overlaps that transfer.

Top module: `dreq_activator`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `xfer_req` is 0 and `tend_n` is 1.
- R2: A change on `dreq_n` reaches the activation logic through a two-flop synchronizer. From the armed state in edge mode with `xfer_ready` high, a falling pin gives a pulse on the fourth rising edge after the fall.
- R3: When `chan_en` goes high while the pin is already low and `xfer_ready` is high, edge mode gives its first pulse on the third rising edge after the enable. No falling edge has to be observed.
- R4: In edge mode, after a low level has been taken the block waits for `xfer_ready`. The pulse comes on the first rising edge at which `xfer_ready` is seen high.
- R5: In edge mode only one pulse is issued per low period of the pin. A further pulse needs the synchronized pin to be seen high and then low again.
- R6: In level mode (`level_mode` = 1), a pulse is issued at every rising edge at which the synchronized pin is low and `xfer_ready` is high. The first pulse comes on the second edge after the enable, and no re-arm is needed.
- R7: While `chan_en` is 0, no pulse is issued whatever the pin and `xfer_ready` do, and `tend_n` stays 1. Clearing `chan_en` while a request is waiting discards that request.
- R8: When `chan_en`, `xfer_done` and `last_xfer` are all 1 and at least one of `src_ext`/`dst_ext` is 1 (1 = external address), `tend_n` is 0 in that same cycle.
- R9: When `xfer_done` and `last_xfer` are 1, both `src_ext` and `dst_ext` are 0, and `ext_wr_busy` is 1, `tend_n` stays 1.
- R10: `tend_n` is 0 for an all-internal last transfer with `ext_wr_busy` at 0. It is 1 in any cycle without both `xfer_done` and `last_xfer`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dreq_n | input | 1 | Raw external request pin, active low |
| level_mode | input | 1 | 1 = low-level sensing, 0 = falling-edge sensing |
| chan_en | input | 1 | Channel enable |
| xfer_ready | input | 1 | Engine can start a transfer |
| xfer_done | input | 1 | A transfer completes this cycle |
| last_xfer | input | 1 | The completing transfer is the final one |
| src_ext | input | 1 | Source address is external |
| dst_ext | input | 1 | Destination address is external |
| ext_wr_busy | input | 1 | An external write cycle runs in parallel |
| xfer_req | output | 1 | Single-cycle transfer request |
| tend_n | output | 1 | Transfer-end strobe, active low |

## Verification
The request pulse is registered, so its latency is counted in rising edges. It is four edges from a pin fall in edge mode, three from an enable over a pending low, two in level mode from enable, and one from `xfer_ready` in the wait state. The bench drives every input on the falling edge and samples after each rising edge at the next falling edge. It records the index of the first pulse in a window and the number of pulses, and compares both with those counts. The end strobe is combinational and is checked in the same cycle its inputs are applied.

// File: rtl/dreq_activator.sv
module dreq_activator #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_n,
  input  logic level_mode,
  input  logic chan_en,
  input  logic xfer_ready,
  input  logic xfer_done,
  input  logic last_xfer,
  input  logic src_ext,
  input  logic dst_ext,
  input  logic ext_wr_busy,
  output logic xfer_req,
  output logic tend_n
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_WAIT, ST_HOLD} st_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic req_low;
  st_t  st, st_n;
  logic fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], dreq_n};

  assign req_low = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    st_n = st;
    fire = 1'b0;
    if (!chan_en) begin
      st_n = ST_IDLE;
    end else if (st == ST_IDLE) begin
      st_n = ST_ARM;
    end else if (level_mode) begin
      st_n = ST_ARM;
      fire = req_low && xfer_ready;
    end else begin
      case (st)
        ST_ARM:  if (req_low) st_n = ST_WAIT;
        ST_WAIT: if (xfer_ready) begin
                   fire = 1'b1;
                   st_n = ST_HOLD;
                 end
        ST_HOLD: if (!req_low) st_n = ST_ARM;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_IDLE;
      xfer_req <= 1'b0;
    end else begin
      st       <= st_n;
      xfer_req <= fire;
    end

  logic internal_only, mask_end;
  assign internal_only = ~src_ext & ~dst_ext;
  assign mask_end      = internal_only & ext_wr_busy;
  assign tend_n        = ~(chan_en & xfer_done & last_xfer & ~mask_end);

  a_r4_edge_pulse_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !$past(level_mode)) |-> ($past(st) == ST_WAIT && $past(xfer_ready)));

  a_r5_rearm_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_HOLD && st == ST_ARM && !$past(level_mode)) |-> !$past(req_low));

  a_r7_no_pulse_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chan_en) |-> !xfer_req);

  a_r6_level_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && $past(level_mode)) |-> ($past(req_low) && $past(xfer_ready)));

  a_r8_external_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && xfer_done && last_xfer && (src_ext || dst_ext)) |-> !tend_n);

  a_r9_masked_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !src_ext && !dst_ext && ext_wr_busy) |-> tend_n);

  a_r10_quiet_without_last: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && last_xfer) |-> tend_n);

endmodule

// File: tb/sim_dreq_activator.sv
module sim_dreq_activator;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dreq_n = 1'b1, level_mode = 1'b0, chan_en = 1'b0, xfer_ready = 1'b0;
  logic xfer_done = 1'b0, last_xfer = 1'b0, src_ext = 1'b0, dst_ext = 1'b0, ext_wr_busy = 1'b0;
  logic xfer_req, tend_n;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dreq_activator u0 (.clk, .rst_n, .dreq_n, .level_mode, .chan_en, .xfer_ready,
    .xfer_done, .last_xfer, .src_ext, .dst_ext, .ext_wr_busy, .xfer_req, .tend_n);

  // {chan_en, xfer_done, last_xfer, src_ext, dst_ext, ext_wr_busy, expected tend_n}
  localparam logic [6:0] TV [8] = '{
    7'b1110000,  // R10 all internal, no overlap
    7'b1110011,  // R9 all internal, overlapped external write
    7'b1111010,  // R8 source external
    7'b1110110,  // R8 destination external
    7'b1111100,  // R8 both external
    7'b1101101,  // R10 not last
    7'b1011001,  // R10 not done
    7'b0111001   // R7 disabled
  };
  localparam int TV_REQ [8] = '{10, 9, 8, 8, 8, 10, 10, 7};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (xfer_req) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  initial begin
    int c, f;
    repeat (2) @(negedge clk);
    chk("R1 req in reset", int'(xfer_req), 0);
    chk("R1 tend in reset", int'(tend_n), 1);
    rst_n = 1'b1;
    run(2, c, f);
    chk("R1 req after reset", c, 0);
    chk("R1 tend after reset", int'(tend_n), 1);

    for (int k = 0; k < 8; k++) begin
      {chan_en, xfer_done, last_xfer, src_ext, dst_ext, ext_wr_busy} = TV[k][6:1];
      #2;
      chk($sformatf("R%0d end strobe vector %0d", TV_REQ[k], k), int'(tend_n), int'(TV[k][0]));
      @(negedge clk);
    end
    {chan_en, xfer_done, last_xfer, src_ext, dst_ext, ext_wr_busy} = '0;

    dreq_n = 1'b0; xfer_ready = 1'b1;
    run(4, c, f);
    chk("R7 pending low while disabled", c, 0);
    chan_en = 1'b1;
    run(5, c, f);
    chk("R3 first pulse edge", f, 3);
    chk("R3 pulse count", c, 1);
    run(6, c, f);
    chk("R5 no repeat while low", c, 0);
    dreq_n = 1'b1;
    run(3, c, f);
    chk("R5 no pulse on release", c, 0);
    dreq_n = 1'b0;
    run(6, c, f);
    chk("R2 fall to pulse latency", f, 4);
    chk("R5 one pulse per low", c, 1);

    dreq_n = 1'b1;
    run(3, c, f);
    xfer_ready = 1'b0; dreq_n = 1'b0;
    run(8, c, f);
    chk("R4 held without ready", c, 0);
    xfer_ready = 1'b1;
    run(3, c, f);
    chk("R4 pulse after ready", f, 1);

    dreq_n = 1'b1;
    run(3, c, f);
    xfer_ready = 1'b0; dreq_n = 1'b0;
    run(4, c, f);
    chan_en = 1'b0;
    run(1, c, f);
    xfer_ready = 1'b1;
    run(3, c, f);
    chk("R7 waiting request dropped", c, 0);
    chan_en = 1'b1;
    run(4, c, f);
    chk("R3 re-enable over pending low", f, 3);

    chan_en = 1'b0;
    run(2, c, f);
    level_mode = 1'b1; chan_en = 1'b1;
    run(5, c, f);
    chk("R6 level first pulse", f, 2);
    chk("R6 level pulse count", c, 4);
    xfer_ready = 1'b0;
    run(3, c, f);
    chk("R6 no pulse without ready", c, 0);
    dreq_n = 1'b1;
    run(3, c, f);
    xfer_ready = 1'b1;
    run(2, c, f);
    chk("R6 no pulse while high", c, 0);
    dreq_n = 1'b0;
    run(4, c, f);
    chk("R6 level fall latency", f, 3);
    chk("R6 level repeat count", c, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule